// File: doc/BRIEF.md
# Command List DMA Sequencer

This block moves sample words between the DSP's memories and an external buffer port. The moves are described by a chain of command blocks stored in the DSP's X data memory. A one-cycle `go` pulse carries the X address of the first block. The sequencer then reads the seven words of that block one at a time over the DSP memory port. It checks whether the transfer must be skipped, and otherwise runs one read and one write per sample. The DSP side steps by a programmable stride. The buffer side either counts upward or wraps inside a circular window.

After the last sample the sequencer can store the final buffer offset back into the command block. It then follows the next-pointer of the block. When a block carries the end-of-list mark, the sequencer finishes that block, drops `busy` and raises a sticky end-of-list flag. Both memory ports are plain request ports with a fixed one-cycle read latency. Byte packing of sample formats is done elsewhere. Here the format code only decides whether a transfer runs.

Top module: `cmdlist_dma`

## Requirements
- R1: After reset, `busy`, `eol_irq`, `dmem_req` and `buf_req` are all low.
- R2: A `go` pulse while idle raises `busy` on the next cycle and clears `eol_irq`. The block then reads the seven command words in order, from X space (`dmem_space` = 0) at local addresses head, head+1, ..., head+6. The words are, in that order: next pointer, control, sample count, DSP start address, buffer offset, buffer base, buffer size minus one.
- R3: Control bit 1 sets the direction. When it is 0, each sample is read from the buffer port and then written to DSP memory. When it is 1, each sample is read from DSP memory and then written to the buffer port, carrying the same data.
- R4: A 14-bit unified DSP address maps to a space and a local address. Addresses 0x0000–0x17FF go to X (code 0, local = address). Addresses 0x1800–0x27FF go to Y (code 1, local = address − 0x1800). Addresses 0x2800–0x37FF go to P (code 2, local = address − 0x2800).
- R5: Sample i uses the unified DSP address start + i × step, modulo 2^14. The step is control bits 23:14.
- R6: `buf_id` carries control bits 8:5. For id 0xE the buffer address wraps: after the address base + size it returns to base. For every other id it increments by one. The first sample uses the offset word.
- R7: When control bit 4 is set and the transfer ran, the block writes the offset that follows the last sample, after any wrap, to X address block + 4. This write comes after the last sample.
- R8: The format field is control bits 12:10. The transfer is skipped in these cases: format 4, 5 or 7; format 0 with a count that is not a multiple of 4; format 1 with an odd count; or a count of zero. A skipped transfer makes no sample access and no write-back.
- R9: After a block finishes, bit 14 of its next-pointer word decides what happens. If the bit is 0, fetching continues at X address bits 12:0 of that word. If the bit is 1, `busy` falls and `eol_irq` is set. The flag holds until the next accepted `go`.
- R10: A `go` pulse while `busy` is high is ignored.
- R11: The two memory ports never issue a request in the same cycle, and neither port issues a request while idle.
- R12: Each command word read, each sample read and each sample write takes its own cycle. A read's data is taken one cycle after its request. A list therefore keeps `busy` high for the sum, over its blocks, of 16 + 3 × (samples moved) + (1 if written back) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, accepted only when idle |
| head_addr | input | 13 | X address of the first command block |
| busy | output | 1 | High while a list is being processed |
| eol_irq | output | 1 | Sticky end-of-list flag |
| dmem_req | output | 1 | DSP memory access request |
| dmem_we | output | 1 | DSP memory write enable |
| dmem_space | output | 2 | Space code: 0 X, 1 Y, 2 P |
| dmem_addr | output | 13 | Local word address within the space |
| dmem_wdata | output | 24 | DSP memory write data |
| dmem_rdata | input | 24 | DSP memory read data, one cycle after request |
| buf_req | output | 1 | Buffer port access request |
| buf_we | output | 1 | Buffer port write enable |
| buf_id | output | 4 | Buffer select from the control word |
| buf_addr | output | 24 | Buffer word address |
| buf_wdata | output | 24 | Buffer write data |
| buf_rdata | input | 24 | Buffer read data, one cycle after request |

## Verification
The assertions assume that every DSP start address and every stride keep the addresses inside the mapped range 0x0000–0x37FF, so no access ever targets the unused fourth space code. They also assume that both memories answer a read in exactly the next cycle. The bench builds its command lists so that every sample address lands inside X, Y or P, and its memory models always answer one cycle after the request. An extra `go` is applied only in the middle of a run, where the design is required to ignore it.

// File: rtl/cmdlist_pkg.sv
`timescale 1ns/1ps
package cmdlist_pkg;

    localparam int DW         = 24;   // DSP word width
    localparam int UAW        = 14;   // unified DSP address width
    localparam int LAW        = 13;   // local address width inside one space
    localparam int DESC_WORDS = 7;

    localparam int X_WORDS = 'h1800;
    localparam int Y_WORDS = 'h1000;
    localparam int P_WORDS = 'h1000;

    // word positions inside a command block
    localparam int W_NEXT = 0;
    localparam int W_CTRL = 1;
    localparam int W_CNT  = 2;
    localparam int W_DSP  = 3;
    localparam int W_OFF  = 4;
    localparam int W_BASE = 5;
    localparam int W_SIZE = 6;

    localparam int EOL_BIT    = 14;
    localparam int STEP_LSB   = 14;
    localparam int STEP_W     = DW - STEP_LSB;
    localparam logic [3:0] BUF_CIRC = 4'hE;

    typedef enum logic [1:0] {
        SP_X    = 2'd0,
        SP_Y    = 2'd1,
        SP_P    = 2'd2,
        SP_NONE = 2'd3
    } space_e;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [2:0]        fmt;
        logic [3:0]        buf_id;
        logic              wb;
        logic              dir;   // 1: DSP -> buffer
    } ctrl_t;

    function automatic ctrl_t ctrl_decode(input logic [DW-1:0] w);
        ctrl_t c;
        c.dir    = w[1];
        c.wb     = w[4];
        c.buf_id = w[8:5];
        c.fmt    = w[12:10];
        c.step   = w[DW-1:STEP_LSB];
        return c;
    endfunction

    // transfer suppressed for reserved formats or counts that do not pack
    function automatic logic xfer_skipped(input logic [2:0] fmt, input logic [DW-1:0] cnt);
        logic s;
        case (fmt)
            3'd4, 3'd5, 3'd7: s = 1'b1;
            3'd0:             s = (cnt[1:0] != 2'b00);
            3'd1:             s = cnt[0];
            default:          s = 1'b0;
        endcase
        return s || (cnt == '0);
    endfunction

endpackage

// File: rtl/cmdlist_dspmap.sv
`timescale 1ns/1ps
module cmdlist_dspmap
    import cmdlist_pkg::*;
(
    input  logic [UAW-1:0] uaddr,
    output space_e         space,
    output logic [LAW-1:0] laddr
);
    localparam int Y_START = X_WORDS;
    localparam int P_START = X_WORDS + Y_WORDS;
    localparam int P_END   = P_START + P_WORDS;

    logic [UAW-1:0] rel;

    always_comb begin
        if (uaddr < UAW'(Y_START)) begin
            space = SP_X;
            rel   = uaddr;
        end else if (uaddr < UAW'(P_START)) begin
            space = SP_Y;
            rel   = uaddr - UAW'(Y_START);
        end else if (uaddr < UAW'(P_END)) begin
            space = SP_P;
            rel   = uaddr - UAW'(P_START);
        end else begin
            space = SP_NONE;
            rel   = uaddr - UAW'(P_END);
        end
        laddr = LAW'(rel);
    end
endmodule

// File: rtl/cmdlist_circ.sv
`timescale 1ns/1ps
module cmdlist_circ #(
    parameter int AW = 24
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] last_ofs,   // window length minus one
    input  logic          circular,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] top;
    assign top = base + last_ofs;
    assign nxt = (circular && (cur == top)) ? base : cur + AW'(1);
endmodule

// File: rtl/cmdlist_dma.sv
`timescale 1ns/1ps
module cmdlist_dma
    import cmdlist_pkg::*;
#(
    parameter int BUF_AW = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [LAW-1:0]    head_addr,
    output logic              busy,
    output logic              eol_irq,
    output logic              dmem_req,
    output logic              dmem_we,
    output logic [1:0]        dmem_space,
    output logic [LAW-1:0]    dmem_addr,
    output logic [DW-1:0]     dmem_wdata,
    input  logic [DW-1:0]     dmem_rdata,
    output logic              buf_req,
    output logic              buf_we,
    output logic [3:0]        buf_id,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [DW-1:0]     buf_wdata,
    input  logic [DW-1:0]     buf_rdata
);
    localparam int IDXW = $clog2(DESC_WORDS);

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_FWAIT, S_DECIDE,
        S_XRD, S_XWAIT, S_XWR, S_WBACK, S_NEXT
    } state_e;

    state_e            state_q;
    logic [IDXW-1:0]   idx_q;
    logic [LAW-1:0]    ptr_q;
    logic [DW-1:0]     desc_q [DESC_WORDS];
    logic [DW-1:0]     left_q;
    logic [DW-1:0]     hold_q;
    logic [UAW-1:0]    dsp_q;
    logic [BUF_AW-1:0] boff_q;
    logic [BUF_AW-1:0] boff_nxt;
    logic              irq_q;

    ctrl_t             ctrl;
    space_e            sp;
    logic [LAW-1:0]    sp_addr;
    logic              skip;
    logic              last;
    logic              unused_bits;

    assign ctrl = ctrl_decode(desc_q[W_CTRL]);
    assign skip = xfer_skipped(ctrl.fmt, desc_q[W_CNT]);
    assign last = (left_q == DW'(1));
    assign unused_bits = ^{desc_q[W_NEXT][DW-1:EOL_BIT+1], desc_q[W_NEXT][EOL_BIT-1:LAW]};

    cmdlist_dspmap u_map (
        .uaddr (dsp_q),
        .space (sp),
        .laddr (sp_addr)
    );

    cmdlist_circ #(.AW(BUF_AW)) u_circ (
        .cur      (boff_q),
        .base     (BUF_AW'(desc_q[W_BASE])),
        .last_ofs (BUF_AW'(desc_q[W_SIZE])),
        .circular (ctrl.buf_id == BUF_CIRC),
        .nxt      (boff_nxt)
    );

    // command words land one cycle after their read request
    always_ff @(posedge clk) begin
        for (int k = 0; k < DESC_WORDS; k++) begin
            if (rst)
                desc_q[k] <= '0;
            else if (state_q == S_FWAIT && idx_q == IDXW'(k))
                desc_q[k] <= dmem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            ptr_q   <= '0;
            left_q  <= '0;
            hold_q  <= '0;
            dsp_q   <= '0;
            boff_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (go) begin
                    ptr_q   <= head_addr;
                    idx_q   <= '0;
                    irq_q   <= 1'b0;
                    state_q <= S_FETCH;
                end
                S_FETCH: state_q <= S_FWAIT;
                S_FWAIT: begin
                    if (idx_q == IDXW'(DESC_WORDS - 1)) begin
                        state_q <= S_DECIDE;
                    end else begin
                        idx_q   <= idx_q + IDXW'(1);
                        state_q <= S_FETCH;
                    end
                end
                S_DECIDE: begin
                    left_q  <= desc_q[W_CNT];
                    dsp_q   <= UAW'(desc_q[W_DSP]);
                    boff_q  <= BUF_AW'(desc_q[W_OFF]);
                    state_q <= skip ? S_NEXT : S_XRD;
                end
                S_XRD:   state_q <= S_XWAIT;
                S_XWAIT: begin
                    hold_q  <= ctrl.dir ? dmem_rdata : buf_rdata;
                    state_q <= S_XWR;
                end
                S_XWR: begin
                    left_q <= left_q - DW'(1);
                    dsp_q  <= dsp_q + UAW'(ctrl.step);
                    boff_q <= boff_nxt;
                    if (last)
                        state_q <= ctrl.wb ? S_WBACK : S_NEXT;
                    else
                        state_q <= S_XRD;
                end
                S_WBACK: state_q <= S_NEXT;
                S_NEXT: begin
                    if (desc_q[W_NEXT][EOL_BIT]) begin
                        irq_q   <= 1'b1;
                        state_q <= S_IDLE;
                    end else begin
                        ptr_q   <= LAW'(desc_q[W_NEXT]);
                        idx_q   <= '0;
                        state_q <= S_FETCH;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        dmem_req   = 1'b0;
        dmem_we    = 1'b0;
        dmem_space = SP_X;
        dmem_addr  = '0;
        dmem_wdata = '0;
        buf_req    = 1'b0;
        buf_we     = 1'b0;
        buf_addr   = boff_q;
        buf_wdata  = hold_q;
        unique case (state_q)
            S_FETCH: begin
                dmem_req  = 1'b1;
                dmem_addr = ptr_q + LAW'(idx_q);
            end
            S_XRD: begin
                if (ctrl.dir) begin
                    dmem_req   = 1'b1;
                    dmem_space = sp;
                    dmem_addr  = sp_addr;
                end else begin
                    buf_req = 1'b1;
                end
            end
            S_XWR: begin
                if (ctrl.dir) begin
                    buf_req = 1'b1;
                    buf_we  = 1'b1;
                end else begin
                    dmem_req   = 1'b1;
                    dmem_we    = 1'b1;
                    dmem_space = sp;
                    dmem_addr  = sp_addr;
                    dmem_wdata = hold_q;
                end
            end
            S_WBACK: begin
                dmem_req   = 1'b1;
                dmem_we    = 1'b1;
                dmem_addr  = ptr_q + LAW'(W_OFF);
                dmem_wdata = DW'(boff_q);
            end
            default: ;
        endcase
    end

    assign buf_id  = ctrl.buf_id;
    assign busy    = (state_q != S_IDLE);
    assign eol_irq = irq_q;

endmodule

// File: rtl/cmdlist_dma_chk.sv
`timescale 1ns/1ps
module cmdlist_dma_chk
    import cmdlist_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           go,
    input logic [LAW-1:0] head_addr,
    input logic           busy,
    input logic           eol_irq,
    input logic           dmem_req,
    input logic           dmem_we,
    input logic [1:0]     dmem_space,
    input logic [LAW-1:0] dmem_addr,
    input logic           buf_req
);
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!dmem_req && !buf_req));

    assert_single_port_R11: assert property (@(posedge clk) disable iff (rst)
        !(dmem_req && buf_req));

    assert_go_starts_R2: assert property (@(posedge clk) disable iff (rst)
        (go && !busy) |=> (busy && !eol_irq));

    assert_first_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        (go && !busy) |=> (dmem_req && !dmem_we && dmem_space == 2'd0
                           && dmem_addr == $past(head_addr)));

    assert_flag_at_end_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> eol_irq);

    assert_flag_only_at_end_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(eol_irq) |-> $fell(busy));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (eol_irq && !go) |=> eol_irq);

    assert_mapped_space_R4: assert property (@(posedge clk) disable iff (rst)
        dmem_req |-> (dmem_space != 2'd3));

    assert_y_range_R4: assert property (@(posedge clk) disable iff (rst)
        (dmem_req && dmem_space == 2'd1) |-> (dmem_addr < LAW'(Y_WORDS)));
endmodule

bind cmdlist_dma cmdlist_dma_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .head_addr  (head_addr),
    .busy       (busy),
    .eol_irq    (eol_irq),
    .dmem_req   (dmem_req),
    .dmem_we    (dmem_we),
    .dmem_space (dmem_space),
    .dmem_addr  (dmem_addr),
    .buf_req    (buf_req)
);

// File: tb/cmdlist_dma_tb.sv
`timescale 1ns/1ps
module cmdlist_dma_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic [12:0] head_addr = '0;
    logic        busy, eol_irq;
    logic        dmem_req, dmem_we;
    logic [1:0]  dmem_space;
    logic [12:0] dmem_addr;
    logic [23:0] dmem_wdata;
    logic [23:0] dmem_rdata = '0;
    logic        buf_req, buf_we;
    logic [3:0]  buf_id;
    logic [23:0] buf_addr, buf_wdata;
    logic [23:0] buf_rdata = '0;

    always #4 clk = ~clk;   // 125 MHz

    cmdlist_dma u_dut (
        .clk(clk), .rst(rst), .go(go), .head_addr(head_addr),
        .busy(busy), .eol_irq(eol_irq),
        .dmem_req(dmem_req), .dmem_we(dmem_we), .dmem_space(dmem_space),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .buf_req(buf_req), .buf_we(buf_we), .buf_id(buf_id), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    typedef struct {
        int    port;   // 0 DSP memory, 1 buffer
        int    we;
        int    sel;    // space code or buffer id
        int    addr;
        int    data;
        string tag;
    } op_t;

    op_t expq[$];
    logic [23:0] dm[int];    // memories seen by the design
    logic [23:0] bm[int];
    logic [23:0] rdm[int];   // reference model copies
    logic [23:0] rbm[int];
    int n_chk = 0;
    int n_err = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] get_dm(input int k);
        return dm.exists(k) ? dm[k] : 24'h0;
    endfunction
    function automatic logic [23:0] get_bm(input int k);
        return bm.exists(k) ? bm[k] : 24'h0;
    endfunction
    function automatic logic [23:0] get_rdm(input int k);
        return rdm.exists(k) ? rdm[k] : 24'h0;
    endfunction
    function automatic logic [23:0] get_rbm(input int k);
        return rbm.exists(k) ? rbm[k] : 24'h0;
    endfunction

    // unified DSP address -> {space, local} key
    function automatic int u2key(input int u);
        if (u < 'h1800) return u;
        else if (u < 'h2800) return (1 << 13) | (u - 'h1800);
        else return (2 << 13) | (u - 'h2800);
    endfunction

    function automatic int bkey(input int id, input int a);
        return (id << 24) | (a & 'hFFFFFF);
    endfunction

    function automatic int mk_ctrl(input int dir, input int wb, input int id,
                                   input int fmt, input int step);
        return (step << 14) | (fmt << 10) | (id << 5) | (wb << 4) | (dir << 1);
    endfunction

    // memory models: one-cycle read latency
    always @(posedge clk) begin
        if (dmem_req) begin
            if (dmem_we) dm[(int'(dmem_space) << 13) | int'(dmem_addr)] = dmem_wdata;
            else dmem_rdata <= get_dm((int'(dmem_space) << 13) | int'(dmem_addr));
        end
        if (buf_req) begin
            if (buf_we) bm[bkey(int'(buf_id), int'(buf_addr))] = buf_wdata;
            else buf_rdata <= get_bm(bkey(int'(buf_id), int'(buf_addr)));
        end
    end

    // per-clock comparison against the reference access stream
    always @(negedge clk) begin
        op_t e;
        op_t a;
        if (!rst && (dmem_req || buf_req)) begin
            check(!(dmem_req && buf_req), "R11 both ports requested", 1, 0);
            a.port = dmem_req ? 0 : 1;
            a.we   = dmem_req ? int'(dmem_we) : int'(buf_we);
            a.sel  = dmem_req ? int'(dmem_space) : int'(buf_id);
            a.addr = dmem_req ? int'(dmem_addr) : int'(buf_addr);
            a.data = dmem_req ? int'(dmem_wdata) : int'(buf_wdata);
            if (expq.size() == 0) begin
                check(1'b0, "R12 unexpected access", a.addr, -1);
            end else begin
                e = expq.pop_front();
                check(a.port == e.port && a.we == e.we && a.sel == e.sel &&
                      a.addr == e.addr && (e.we == 0 || a.data == e.data),
                      $sformatf("%s access port/we/sel/addr/data %0d/%0d/%0h/%0h/%0h vs",
                                e.tag, a.port, a.we, a.sel, a.addr, a.data),
                      e.addr, e.data);
            end
        end
    end

    task automatic push(input int port, input int we, input int sel, input int addr,
                        input int data, input string tag);
        op_t o;
        o.port = port; o.we = we; o.sel = sel; o.addr = addr; o.data = data; o.tag = tag;
        expq.push_back(o);
    endtask

    // behavioural walk of the list; returns the expected busy length
    task automatic build(input int head, output int cycles);
        int p, done, dir, wb, id, fmt, step, cnt, off, u, k, v, skip;
        int d[7];
        p = head; done = 0; cycles = 0;
        while (done == 0) begin
            for (int w = 0; w < 7; w++) begin
                d[w] = int'(get_rdm(p + w));
                push(0, 0, 0, p + w, 0, "R2");
            end
            cycles += 16;
            dir  = (d[1] >> 1) & 1;
            wb   = (d[1] >> 4) & 1;
            id   = (d[1] >> 5) & 15;
            fmt  = (d[1] >> 10) & 7;
            step = (d[1] >> 14) & 1023;
            cnt  = d[2];
            skip = (fmt == 4 || fmt == 5 || fmt == 7 || (fmt == 0 && cnt % 4 != 0) ||
                    (fmt == 1 && cnt % 2 != 0) || cnt == 0) ? 1 : 0;
            if (skip == 0) begin
                off = d[4];
                for (int i = 0; i < cnt; i++) begin
                    u = ((d[3] & 'h3FFF) + i * step) & 'h3FFF;
                    k = u2key(u);
                    if (dir == 0) begin
                        v = int'(get_rbm(bkey(id, off)));
                        push(1, 0, id, off, 0, "R6");
                        rdm[k] = v[23:0];
                        push(0, 1, k >> 13, k & 'h1FFF, v, "R4");
                    end else begin
                        v = int'(get_rdm(k));
                        push(0, 0, k >> 13, k & 'h1FFF, 0, "R5");
                        rbm[bkey(id, off)] = v[23:0];
                        push(1, 1, id, off, v, "R3");
                    end
                    if (id == 14 && off == ((d[5] + d[6]) & 'hFFFFFF)) off = d[5];
                    else off = (off + 1) & 'hFFFFFF;
                    cycles += 3;
                end
                if (wb == 1) begin
                    rdm[p + 4] = off[23:0];
                    push(0, 1, 0, p + 4, off, "R7");
                    cycles += 1;
                end
            end
            if (((d[0] >> 14) & 1) == 1) done = 1;
            else p = d[0] & 'h1FFF;
        end
    endtask

    task automatic put_blk(input int a, input int nxt, input int ctl, input int cnt,
                           input int dsp, input int off, input int base, input int size);
        int w[7];
        w[0] = nxt; w[1] = ctl; w[2] = cnt; w[3] = dsp; w[4] = off; w[5] = base; w[6] = size;
        for (int i = 0; i < 7; i++) begin
            dm[a + i]  = w[i][23:0];
            rdm[a + i] = w[i][23:0];
        end
    endtask

    task automatic pre_d(input int u, input int v);
        dm[u2key(u)]  = v[23:0];
        rdm[u2key(u)] = v[23:0];
    endtask

    task automatic pre_b(input int id, input int a, input int v);
        bm[bkey(id, a)]  = v[23:0];
        rbm[bkey(id, a)] = v[23:0];
    endtask

    // start a list, optionally pulse go again mid-run, measure busy length
    task automatic run_list(input int head, input int exp_cyc, input int poke_at);
        int cyc;
        @(negedge clk);
        go = 1'b1; head_addr = head[12:0];
        @(negedge clk);
        go = 1'b0;
        check(busy == 1'b1, "R2 busy after go", busy, 1);
        check(eol_irq == 1'b0, "R2 flag cleared by go", eol_irq, 0);
        cyc = 0;
        while (busy) begin
            cyc++;
            if (cyc == poke_at) begin go = 1'b1; head_addr = 13'h040; end
            else go = 1'b0;
            @(negedge clk);
        end
        go = 1'b0;
        check(cyc == exp_cyc, "R12 busy length", cyc, exp_cyc);
        check(eol_irq == 1'b1, "R9 end flag set", eol_irq, 1);
        check(expq.size() == 0, "R9 accesses left unissued", expq.size(), 0);
        repeat (3) @(negedge clk);
        check(eol_irq == 1'b1 && busy == 1'b0, "R9 flag held while idle", eol_irq, 1);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(busy == 0 && eol_irq == 0 && dmem_req == 0 && buf_req == 0,
              "R1 reset state", {busy, eol_irq, dmem_req, buf_req}, 0);

        // R3: buffer to DSP, linear, single block
        put_blk('h040, 'h4000, mk_ctrl(0, 0, 0, 2, 1), 3, 'h0200, 'h10, 0, 0);
        pre_b(0, 'h10, 'h123456); pre_b(0, 'h11, 'h00ABCD); pre_b(0, 'h12, 'h7FFFFF);
        build('h040, cyc);
        run_list('h040, cyc, -1);
        check(get_dm('h202) == 24'h7FFFFF, "R3 buffer to DSP data", get_dm('h202), 'h7FFFFF);

        // R5 R6 R7 R10: circular DSP-to-buffer with stride into Y, then buffer-to-P block
        put_blk('h060, 'h0070, mk_ctrl(1, 1, 14, 6, 2), 5, 'h1900, 'h102, 'h100, 3);
        put_blk('h070, 'h4000, mk_ctrl(0, 0, 1, 3, 1), 2, 'h2A00, 'h20, 0, 0);
        for (int i = 0; i < 5; i++) pre_d('h1900 + 2 * i, 'h100000 + i);
        pre_b(1, 'h20, 'hAAAAAA); pre_b(1, 'h21, 'h555555);
        build('h060, cyc);
        run_list('h060, cyc, 5);   // R10: extra go mid-run must be ignored
        check(get_bm(bkey(14, 'h100)) == 24'h100002, "R6 circular wrap to base",
              get_bm(bkey(14, 'h100)), 'h100002);
        check(get_bm(bkey(14, 'h103)) == 24'h100001, "R5 stride of two",
              get_bm(bkey(14, 'h103)), 'h100001);
        check(get_dm('h064) == 24'h000103, "R7 offset written back",
              get_dm('h064), 'h103);
        check(get_dm((2 << 13) | 'h200) == 24'hAAAAAA, "R4 P space mapping",
              get_dm((2 << 13) | 'h200), 'hAAAAAA);
        check(get_dm((2 << 13) | 'h201) == 24'h555555, "R4 P space second word",
              get_dm((2 << 13) | 'h201), 'h555555);

        // R8: skip rules along a chain, last block legal
        put_blk('h080, 'h0090, mk_ctrl(0, 1, 0, 4, 1), 2, 'h0400, 'h40, 0, 0);
        put_blk('h090, 'h00A0, mk_ctrl(0, 1, 0, 0, 1), 6, 'h0400, 'h40, 0, 0);
        put_blk('h0A0, 'h00B0, mk_ctrl(0, 0, 0, 1, 1), 5, 'h0400, 'h40, 0, 0);
        put_blk('h0B0, 'h00C0, mk_ctrl(0, 0, 0, 5, 1), 2, 'h0400, 'h40, 0, 0);
        put_blk('h0C0, 'h00D0, mk_ctrl(0, 0, 0, 7, 1), 1, 'h0400, 'h40, 0, 0);
        put_blk('h0D0, 'h4000, mk_ctrl(0, 0, 0, 0, 1), 4, 'h0300, 'h30, 0, 0);
        for (int i = 0; i < 6; i++) pre_b(0, 'h40 + i, 'h0F0F00 + i);
        for (int i = 0; i < 4; i++) pre_b(0, 'h30 + i, 'h300000 + i);
        build('h080, cyc);
        run_list('h080, cyc, -1);
        check(get_dm('h400) == 24'h0, "R8 skipped block moved nothing", get_dm('h400), 0);
        check(get_dm('h084) == 24'h40, "R8 skipped block not written back", get_dm('h084), 'h40);
        check(get_dm('h303) == 24'h300003, "R8 legal 8-bit count moved", get_dm('h303), 'h300003);

        // whole-memory agreement with the reference model
        foreach (rdm[k]) check(get_dm(k) == rdm[k], "R3 DSP memory image", get_dm(k), rdm[k]);
        foreach (rbm[k]) check(get_bm(k) == rbm[k], "R6 buffer image", get_bm(k), rbm[k]);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule